// File: doc/BRIEF.md
# Wake Event and PME Controller

This block sits beside a network interface and keeps a record of the events that should wake a sleeping system. It records three kinds of event as sticky flags. The first is a link-status change pulse from the link polling logic. The second is a pulse from the wake-pattern matcher. The third is a pulse from the magic-packet detector. From these flags and a small set of control bits, the block drives a power-management-event request and a remote-wake pin. The remote-wake pin is active low and is modelled as an output enable plus a data value.

Software reaches the block through a two-word synchronous register port. Word 0 holds the control bits and word 1 holds the status flags. Some control bits can only be changed while the host has the interface stopped or suspended. The block has three reset classes:
- Power-on reset clears everything.
- Hardware reset clears the control bits but keeps the flags.
- Software reset clears only the freely writable control bits.

The power-good input is brought through a synchronizer before it gates the wake pin.

Top module: `wake_pme_ctrl`

## Requirements
- R1: Status bit 0 (link-change flag) sets one cycle after a `link_chg_i` pulse while control bit 2 (link-change mode) is 1. It stays clear if that mode bit is 0.
- R2: Status bit 1 (pattern flag) sets after a `pat_hit_i` pulse only while control bit 3 (pattern mode) is 1.
- R3: Status bit 2 (magic-packet flag) sets after any `magic_hit_i` pulse.
- R4: Writing 1 to a status bit clears it, and writing 0 leaves it. If a set event and a clearing write land in the same cycle, the flag ends up set.
- R5: Hardware and software resets leave the status flags unchanged. Only `por_i` clears them.
- R6: `pme_o` is 1 when control bit 1 (override) is 1 and the magic-packet or link-change flag is set. Otherwise it is 1 only when control bit 0 (PME enable) is 1 and any flag is set.
- R7: When control bit 4 (gate) is 1 and `pwr_good_i` has been low for two clock edges, `wake_oe_o` is 0 whatever the flags hold.
- R8: Let "any" mean that at least one flag is set.
  - With control bit 5 (push-pull) at 1, `wake_oe_o` is 1 and `wake_do_o` is the inverse of "any".
  - With it at 0 (open drain), `wake_oe_o` equals "any" and `wake_do_o` is 0.
- R9: Control bits 1, 2, 4 and 5 take a write only while `stop_i` or `suspend_i` is 1. At other times the write is ignored for them. Bits 0 and 3 take writes at any time.
- R10: `hw_rst_i` clears all control bits. `sw_rst_i` clears bits 0 and 3, keeps bits 1, 2, 4 and 5, and blocks a control write in the same cycle.
- R11: `reg_rdata_o` shows the control word when `reg_addr_i` is 0 and the flags (bits 2..0) when it is 1, combinationally. All state reads 0 after power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| hw_rst_i | input | 1 | Hardware reset, synchronous, active high |
| sw_rst_i | input | 1 | Software reset, synchronous, active high |
| stop_i | input | 1 | Interface stopped state |
| suspend_i | input | 1 | Interface suspended state |
| link_chg_i | input | 1 | Link-status change pulse |
| pat_hit_i | input | 1 | Wake-pattern match pulse |
| magic_hit_i | input | 1 | Magic-packet match pulse |
| pwr_good_i | input | 1 | Power-good level, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register word select |
| reg_wdata_i | input | 6 | Register write data |
| reg_rdata_o | output | 6 | Register read data |
| pme_o | output | 1 | Power-management-event request |
| wake_oe_o | output | 1 | Remote-wake pin output enable |
| wake_do_o | output | 1 | Remote-wake pin data (active low) |

## Verification
The timing of each result is fixed:
- A write or an event pulse changes state at the next rising edge. Because `pme_o` and the wake pin are decoded combinationally from that state, they follow on the same edge.
- Read data follows `reg_addr_i` with no edge at all.
- A change on `pwr_good_i` reaches the wake pin only after the second rising edge.

The bench drives every input on the falling edge and samples one falling edge later. For power-good it waits three falling edges, and it checks the two-edge delay once, edge by edge. The output decode is swept over every combination of flags, four output-related control bits and the power-good level.

// File: rtl/wake_pme_pkg.sv
package wake_pme_pkg;

    localparam int CTRL_W = 6;
    localparam int NFLAG  = 3;
    localparam int REG_W  = CTRL_W;

    // bit 5 push_pull, 4 gate, 3 pat_mode, 2 lc_mode, 1 pme_ovr, 0 pme_en
    typedef struct packed {
        logic push_pull;
        logic gate;
        logic pat_mode;
        logic lc_mode;
        logic pme_ovr;
        logic pme_en;
    } ctrl_t;

    // bit 2 magic, 1 pat, 0 lc
    typedef struct packed {
        logic magic;
        logic pat;
        logic lc;
    } flags_t;

    typedef struct packed {
        logic oe;
        logic dat;
    } pin_t;

    typedef enum logic [0:0] {
        ADDR_CTRL = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    // Bits that need stop or suspend for writes and survive software reset.
    localparam logic [CTRL_W-1:0] LOCKED_MASK = 6'b110110;
    // Bits cleared by software reset.
    localparam logic [CTRL_W-1:0] SWRST_MASK  = 6'b001001;

    function automatic logic pme_eval(input ctrl_t c, input flags_t f);
        logic forced;
        logic normal;
        forced = c.pme_ovr && (f.magic || f.lc);
        normal = c.pme_en && (|f);
        return forced || normal;
    endfunction

    function automatic pin_t wake_eval(input ctrl_t c, input flags_t f, input logic pg);
        pin_t p;
        if (c.gate && !pg) begin
            p.oe  = 1'b0;
            p.dat = 1'b0;
        end else if (c.push_pull) begin
            p.oe  = 1'b1;
            p.dat = ~(|f);
        end else begin
            p.oe  = |f;
            p.dat = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/wake_pg_sync.sv
module wake_pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wake_ctrl_regs.sv
module wake_ctrl_regs
    import wake_pme_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              hw_rst_i,
    input  logic              sw_rst_i,
    input  logic              cfg_open_i,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o
);
    logic [CTRL_W-1:0] q;

    generate
        for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (por_i || hw_rst_i) begin
                    q[i] <= 1'b0;
                end else if (sw_rst_i) begin
                    if (SWRST_MASK[i]) q[i] <= 1'b0;
                end else if (wr_i && (!LOCKED_MASK[i] || cfg_open_i)) begin
                    q[i] <= wdata_i[i];
                end
            end
        end
    endgenerate

    assign ctrl_o = ctrl_t'(q);

    // R9: locked bits hold across a write made while closed
    assert_locked_hold_R9: assert property (@(posedge clk) disable iff (por_i || hw_rst_i)
        (wr_i && !cfg_open_i) |=> ((q & LOCKED_MASK) == $past(q & LOCKED_MASK)));

    // R10: hardware reset leaves every control bit clear
    assert_hw_clear_R10: assert property (@(posedge clk) disable iff (por_i)
        hw_rst_i |=> (q == '0));

    // R10: software reset keeps the locked bits
    assert_sw_keep_R10: assert property (@(posedge clk) disable iff (por_i || hw_rst_i)
        sw_rst_i |=> ((q & LOCKED_MASK) == $past(q & LOCKED_MASK)));
endmodule

// File: rtl/wake_status_flags.sv
module wake_status_flags
    import wake_pme_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output flags_t           flags_o
);
    logic [NFLAG-1:0] f;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (por_i)         f[i] <= 1'b0;
                else if (set_i[i]) f[i] <= 1'b1;
                else if (clr_i[i]) f[i] <= 1'b0;
            end

            // R4: a set event wins over a clear in the same cycle
            assert_set_wins_R4: assert property (@(posedge clk) disable iff (por_i)
                set_i[i] |=> f[i]);

            // R5: a flag stays set until written with 1
            assert_sticky_R5: assert property (@(posedge clk) disable iff (por_i)
                (f[i] && !clr_i[i]) |=> f[i]);

            // R1: no flag appears without an event
            assert_no_spurious_R1: assert property (@(posedge clk) disable iff (por_i)
                (!f[i] && !set_i[i]) |=> !f[i]);
        end
    endgenerate

    assign flags_o = flags_t'(f);
endmodule

// File: rtl/wake_out_drive.sv
module wake_out_drive
    import wake_pme_pkg::*;
(
    input  ctrl_t  ctrl_i,
    input  flags_t flags_i,
    input  logic   pg_i,
    output logic   pme_o,
    output logic   wake_oe_o,
    output logic   wake_do_o
);
    pin_t pin;

    always_comb begin
        pme_o = pme_eval(ctrl_i, flags_i);
        pin   = wake_eval(ctrl_i, flags_i, pg_i);
    end

    assign wake_oe_o = pin.oe;
    assign wake_do_o = pin.dat;
endmodule

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl
    import wake_pme_pkg::*;
#(
    parameter int PG_SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             hw_rst_i,
    input  logic             sw_rst_i,
    input  logic             stop_i,
    input  logic             suspend_i,
    input  logic             link_chg_i,
    input  logic             pat_hit_i,
    input  logic             magic_hit_i,
    input  logic             pwr_good_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             pme_o,
    output logic             wake_oe_o,
    output logic             wake_do_o
);
    ctrl_t            ctrl;
    flags_t           flags;
    logic             pg_s;
    logic             wr_ctrl;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;

    assign wr_ctrl  = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
    assign flag_clr = (reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_STAT)) ?
                      reg_wdata_i[NFLAG-1:0] : '0;
    assign flag_set = {magic_hit_i,
                       pat_hit_i  && ctrl.pat_mode,
                       link_chg_i && ctrl.lc_mode};

    wake_pg_sync #(.STAGES(PG_SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (por_i || hw_rst_i),
        .d_i (pwr_good_i),
        .q_o (pg_s)
    );

    wake_ctrl_regs u_ctrl (
        .clk        (clk),
        .por_i      (por_i),
        .hw_rst_i   (hw_rst_i),
        .sw_rst_i   (sw_rst_i),
        .cfg_open_i (stop_i || suspend_i),
        .wr_i       (wr_ctrl),
        .wdata_i    (reg_wdata_i),
        .ctrl_o     (ctrl)
    );

    wake_status_flags u_flags (
        .clk     (clk),
        .por_i   (por_i),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    wake_out_drive u_out (
        .ctrl_i    (ctrl),
        .flags_i   (flags),
        .pg_i      (pg_s),
        .pme_o     (pme_o),
        .wake_oe_o (wake_oe_o),
        .wake_do_o (wake_do_o)
    );

    always_comb begin
        if (reg_addr_e'(reg_addr_i) == ADDR_CTRL) reg_rdata_o = REG_W'(ctrl);
        else reg_rdata_o = {{(REG_W-NFLAG){1'b0}}, flags};
    end

    // R6: override forces the request on a magic-packet or link flag
    assert_ovr_pme_R6: assert property (@(posedge clk) disable iff (por_i)
        (ctrl.pme_ovr && (flags.magic || flags.lc)) |-> pme_o);

    // R6: no request without any flag
    assert_no_flag_no_pme_R6: assert property (@(posedge clk) disable iff (por_i)
        (flags == '0) |-> !pme_o);

    // R7: gated pin floats while synchronized power-good is low
    assert_gate_hiz_R7: assert property (@(posedge clk) disable iff (por_i)
        (ctrl.gate && !pg_s) |-> !wake_oe_o);

    // R8: open-drain mode never drives high
    assert_od_low_only_R8: assert property (@(posedge clk) disable iff (por_i)
        (!ctrl.push_pull && wake_oe_o) |-> !wake_do_o);
endmodule

// File: tb/test_wake_pme_ctrl.sv
`timescale 1ns/1ps
module test_wake_pme_ctrl;
    logic clk = 1'b0;
    logic por = 1'b1, hw_rst = 1'b0, sw_rst = 1'b0, stop = 1'b0, susp = 1'b0;
    logic lchg = 1'b0, phit = 1'b0, mhit = 1'b0, pg = 1'b0;
    logic wr = 1'b0, addr = 1'b0;
    logic [5:0] wdata = '0;
    logic [5:0] rdata;
    logic pme, oe, dout;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wake_pme_ctrl i_wake_pme_ctrl (
        .clk(clk), .por_i(por), .hw_rst_i(hw_rst), .sw_rst_i(sw_rst),
        .stop_i(stop), .suspend_i(susp), .link_chg_i(lchg), .pat_hit_i(phit),
        .magic_hit_i(mhit), .pwr_good_i(pg), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pme_o(pme),
        .wake_oe_o(oe), .wake_do_o(dout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic a, input logic [5:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic rreg(input logic a, output logic [5:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic events(input logic [2:0] f);
        @(negedge clk); lchg = f[0]; phit = f[1]; mhit = f[2];
        @(negedge clk); lchg = 1'b0; phit = 1'b0; mhit = 1'b0;
    endtask

    task automatic pulse_rst(input int which);
        @(negedge clk);
        if (which == 0) por = 1'b1; else if (which == 1) hw_rst = 1'b1; else sw_rst = 1'b1;
        @(negedge clk); por = 1'b0; hw_rst = 1'b0; sw_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] d;
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        // R11: reset state
        rreg(0, d); chk("R11 ctrl after por", d, 0);
        rreg(1, d); chk("R11 flags after por", d, 0);
        chk("R11 pme after por", pme, 0);
        chk("R11 oe after por", oe, 0);

        // R9: locked bits ignore writes while open conditions absent
        wreg(0, 6'b111111); rreg(0, d); chk("R9 closed write", d, 6'b001001);
        susp = 1'b1; wreg(0, 6'b111111); rreg(0, d); chk("R9 suspend write", d, 6'b111111);
        susp = 1'b0; wreg(0, 6'b000000); rreg(0, d); chk("R9 closed clear", d, 6'b110110);
        stop = 1'b1; wreg(0, 6'b000000); rreg(0, d); chk("R9 stop write", d, 6'b000000);

        // R1, R2, R3: mode gating of events
        events(3'b011); rreg(1, d); chk("R1 R2 modes off", d, 0);
        events(3'b100); rreg(1, d); chk("R3 magic", d, 3'b100);
        wreg(0, 6'b000100); events(3'b011); rreg(1, d); chk("R1 lc mode", d, 3'b101);
        wreg(0, 6'b001000); events(3'b010); rreg(1, d); chk("R2 pat mode", d, 3'b111);

        // R4: write-one-to-clear and set priority
        wreg(1, 3'b000); rreg(1, d); chk("R4 write zero", d, 3'b111);
        wreg(1, 3'b101); rreg(1, d); chk("R4 clear two", d, 3'b010);
        wreg(0, 6'b001100);
        @(negedge clk); wr = 1'b1; addr = 1'b1; wdata = 6'b000011; lchg = 1'b1;
        @(negedge clk); wr = 1'b0; wdata = '0; lchg = 1'b0;
        rreg(1, d); chk("R4 set wins", d, 3'b001);
        events(3'b110); rreg(1, d); chk("R4 refill", d, 3'b111);

        // R5, R10: reset classes
        wreg(0, 6'b111111);
        pulse_rst(2);
        rreg(0, d); chk("R10 sw reset ctrl", d, 6'b110110);
        rreg(1, d); chk("R5 flags after sw reset", d, 3'b111);
        wreg(0, 6'b111111);
        @(negedge clk); sw_rst = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 6'b000000;
        @(negedge clk); sw_rst = 1'b0; wr = 1'b0;
        rreg(0, d); chk("R10 sw reset blocks write", d, 6'b110110);
        pulse_rst(1);
        rreg(0, d); chk("R10 hw reset ctrl", d, 0);
        rreg(1, d); chk("R5 flags after hw reset", d, 3'b111);
        pulse_rst(0);
        rreg(1, d); chk("R5 flags after por", d, 0);

        // R7: two-edge synchronizer delay
        pg = 1'b1;
        wreg(0, 6'b110000);
        repeat (3) @(negedge clk);
        chk("R7 pg high drives", oe, 1);
        pg = 1'b0;
        @(negedge clk); chk("R7 one edge still driven", oe, 1);
        @(negedge clk); chk("R7 two edges float", oe, 0);

        // R6, R7, R8: sweep of output decode
        for (int f = 0; f < 8; f++) begin
            for (int c = 0; c < 16; c++) begin
                for (int p = 0; p < 2; p++) begin
                    logic en, ovr, gt, pp, any, e_pme, e_oe, e_do;
                    logic [2:0] fv;
                    fv = f[2:0];
                    en = c[0]; ovr = c[1]; gt = c[2]; pp = c[3];
                    wreg(0, {pp, gt, 1'b1, 1'b1, ovr, en});
                    wreg(1, 3'b111);
                    if (fv != 0) events(fv);
                    pg = p[0];
                    repeat (3) @(negedge clk);
                    any   = |fv;
                    e_pme = (ovr && (fv[0] || fv[2])) || (en && any);
                    if (gt && !pg) begin e_oe = 1'b0; e_do = 1'b0; end
                    else if (pp)   begin e_oe = 1'b1; e_do = ~any; end
                    else           begin e_oe = any;  e_do = 1'b0; end
                    chk("R6 pme sweep", pme, e_pme);
                    chk(gt && !pg ? "R7 oe sweep" : "R8 oe sweep", oe, e_oe);
                    if (e_oe) chk("R8 data sweep", dout, e_do);
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule